// File: doc/BRIEF.md
# Banked Scratchpad Request Arbiter

This block sits in front of a scratchpad memory that is split into several independently addressed banks. A set of requester ports each offers at most one request per cycle: an address, a read/write flag, write data, a tag and a requester ID. Each cycle the block takes the bank number from a bit field of every address. It then hands each bank to at most one port. When two or more ports want the same bank, the port with the lowest index wins.

A winning port sees `req_ready` high in that cycle, and its request is consumed. A losing port does not see `req_ready`. Its request stays offered and competes again in the next cycle. Every consumed read returns a response on the output port with the same index. That response carries the stored data word, the tag and the requester ID. Consumed writes update the bank storage. They answer with a response only when the write-response parameter is set.

Three free-running counters track consumed reads, consumed writes and lost arbitration attempts. Each bank is a plain synchronous single-port RAM inside the block.

Top module: `smem_bank_arb`

## Requirements
- R1: The bank index of a request is `addr[BANK_LSB +: log2(NUM_BANKS)]`. The row within the bank is formed from the remaining address bits, lowest bits first. With the defaults (`BANK_LSB`=2, 4 banks, 8-bit address), the bank is `addr[3:2]` and the row is `{addr[7:4], addr[1:0]}`.
- R2: When several valid ports name the same bank in one cycle, the port with the lowest index is granted that bank. A valid request on port 0 is therefore always granted.
- R3: In any cycle, no bank is granted to more than one port.
- R4: `req_ready[p]` is high only in a cycle where port p is valid and granted. A valid request that is not granted is not consumed, and it is granted in a later cycle once no lower-index port claims its bank.
- R5: A granted read produces `rsp_valid[p]` on the same port index `RSP_LAT` cycles after the grant, where the default is 1. The response carries the request's tag and requester ID, and the data word last written to that bank row.
- R6: A granted write stores its data. When `WR_RSP_EN`=1, it produces a response `RSP_LAT` cycles later with the tag, the requester ID and zero data. When `WR_RSP_EN`=0, it produces no response.
- R7: `cnt_reads` increments by the number of granted reads in a cycle, and `cnt_writes` increments by the number of granted writes.
- R8: `cnt_stalls` increments by the number of valid requests that are not granted in a cycle.
- R9: While reset is active and right after it, all counters read zero and no `rsp_valid` bit is high.
- R10: Valid requests that all name different banks are granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request offered on each port |
| req_ready | output | NUM_PORTS | Request granted and consumed this cycle |
| req_write | input | NUM_PORTS | 1 = write, 0 = read |
| req_addr | input | NUM_PORTS*ADDR_W | Word addresses, port 0 in the low bits |
| req_wdata | input | NUM_PORTS*DATA_W | Write data per port |
| req_tag | input | NUM_PORTS*TAG_W | Request tag per port |
| req_rid | input | NUM_PORTS*RID_W | Requester ID per port |
| rsp_valid | output | NUM_PORTS | One-cycle response pulse per port |
| rsp_tag | output | NUM_PORTS*TAG_W | Returned tag |
| rsp_rid | output | NUM_PORTS*RID_W | Returned requester ID |
| rsp_data | output | NUM_PORTS*DATA_W | Read data, or zero for a write |
| cnt_reads | output | CNT_W | Granted read count |
| cnt_writes | output | CNT_W | Granted write count |
| cnt_stalls | output | CNT_W | Lost arbitration count |

## Verification
The first pattern spreads the four ports across four distinct banks, both for writes and for reads. This separates correct parallel granting from needless serialisation. It also shows that each response returns on its own port with its own data.

The second pattern puts all four ports on one bank, with addresses that differ only outside the bank field. This exposes the grant order cycle by cycle, shows that losers keep their requests, and fixes the exact stall total.

A second instance with write responses disabled sees the same traffic. Write responses that vanish there while reads still answer separate the write-response switch from the rest of the response path.

// File: rtl/smem_bank_arb_pkg.sv
package smem_bank_arb_pkg;

    // index width that never collapses to zero bits
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/smem_bank_grant.sv
module smem_bank_grant #(
    parameter int NP     = 4,
    parameter int NB     = 4,
    parameter int BSEL_W = 2,
    parameter int PSEL_W = 2,
    parameter int SCNT_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NP-1:0]                valid,
    input  logic [NP-1:0][BSEL_W-1:0]    bank,
    output logic [NP-1:0]                grant,
    output logic [NB-1:0]                bank_en,
    output logic [NB-1:0][PSEL_W-1:0]    bank_port,
    output logic [SCNT_W-1:0]            lose_n
);

    logic [NB-1:0] claimed;

    // fixed-priority scan: lowest port index claims a bank first
    always_comb begin
        claimed   = '0;
        grant     = '0;
        bank_en   = '0;
        bank_port = '0;
        lose_n    = '0;
        for (int p = 0; p < NP; p++) begin
            if (valid[p]) begin
                if (!claimed[bank[p]]) begin
                    claimed[bank[p]]   = 1'b1;
                    grant[p]           = 1'b1;
                    bank_en[bank[p]]   = 1'b1;
                    bank_port[bank[p]] = PSEL_W'(p);
                end else begin
                    lose_n = lose_n + SCNT_W'(1);
                end
            end
        end
    end

    AST_PORT0_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        valid[0] |-> grant[0]); // R2

    AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~valid) == '0); // R4

endmodule

// File: rtl/smem_bank_ram.sv
module smem_bank_ram #(
    parameter int ROWS   = 64,
    parameter int ROW_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem_q[row] <= wdata;
            end else begin
                rdata <= mem_q[row];
            end
        end
    end

endmodule

// File: rtl/smem_rsp_delay.sv
module smem_rsp_delay #(
    parameter int STAGES = 0,
    parameter int W      = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_pay,
    output logic         out_valid,
    output logic [W-1:0] out_pay
);

    generate
        if (STAGES == 0) begin : g_pass
            assign out_valid = in_valid;
            assign out_pay   = in_pay;
        end else begin : g_pipe
            logic [STAGES-1:0]        vld_d, vld_q;
            logic [STAGES-1:0][W-1:0] pay_d, pay_q;

            always_comb begin
                vld_d[0] = in_valid;
                pay_d[0] = in_pay;
                for (int s = 1; s < STAGES; s++) begin
                    vld_d[s] = vld_q[s-1];
                    pay_d[s] = pay_q[s-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= '0;
                end else begin
                    vld_q <= vld_d;
                end
                pay_q <= pay_d;
            end

            assign out_valid = vld_q[STAGES-1];
            assign out_pay   = pay_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/smem_bank_arb.sv
module smem_bank_arb
    import smem_bank_arb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_BANKS = 4,
    parameter int BANK_LSB  = 2,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 8,
    parameter int RID_W     = 4,
    parameter int RSP_LAT   = 1,
    parameter bit WR_RSP_EN = 1'b1,
    parameter int CNT_W     = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    output logic [NUM_PORTS-1:0]        req_ready,
    input  logic [NUM_PORTS-1:0]        req_write,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0] req_wdata,
    input  logic [NUM_PORTS*TAG_W-1:0]  req_tag,
    input  logic [NUM_PORTS*RID_W-1:0]  req_rid,
    output logic [NUM_PORTS-1:0]        rsp_valid,
    output logic [NUM_PORTS*TAG_W-1:0]  rsp_tag,
    output logic [NUM_PORTS*RID_W-1:0]  rsp_rid,
    output logic [NUM_PORTS*DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]            cnt_reads,
    output logic [CNT_W-1:0]            cnt_writes,
    output logic [CNT_W-1:0]            cnt_stalls
);

    localparam int NP     = NUM_PORTS;
    localparam int NB     = NUM_BANKS;
    localparam int BSEL_W = $clog2(NB);
    localparam int PSEL_W = idx_w(NP);
    localparam int ROW_W  = ADDR_W - BSEL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int SCNT_W = $clog2(NP + 1);
    localparam int PAY_W  = TAG_W + RID_W + DATA_W;

    typedef struct packed {
        logic [NP-1:0]             s1_valid;
        logic [NP-1:0]             s1_read;
        logic [NP-1:0][TAG_W-1:0]  s1_tag;
        logic [NP-1:0][RID_W-1:0]  s1_rid;
        logic [NP-1:0][BSEL_W-1:0] s1_bank;
        logic [CNT_W-1:0]          rd_cnt;
        logic [CNT_W-1:0]          wr_cnt;
        logic [CNT_W-1:0]          st_cnt;
    } state_t;

    state_t st_d, st_q;

    logic [NP-1:0][ADDR_W-1:0] addr_v;
    logic [NP-1:0][DATA_W-1:0] wdata_v;
    logic [NP-1:0][TAG_W-1:0]  tag_v;
    logic [NP-1:0][RID_W-1:0]  rid_v;
    logic [NP-1:0][BSEL_W-1:0] bank_v;
    logic [NP-1:0][ROW_W-1:0]  row_v;

    assign addr_v  = req_addr;
    assign wdata_v = req_wdata;
    assign tag_v   = req_tag;
    assign rid_v   = req_rid;

    // row = address with the bank field squeezed out, lowest bits first
    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        logic [ROW_W-1:0] r;
        for (int i = 0; i < ROW_W; i++) begin
            r[i] = (i < BANK_LSB) ? a[i] : a[i + BSEL_W];
        end
        return r;
    endfunction

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            bank_v[p] = addr_v[p][BANK_LSB +: BSEL_W];
            row_v[p]  = row_of(addr_v[p]);
        end
    end

    logic [NP-1:0]             grant;
    logic [NB-1:0]             bank_en;
    logic [NB-1:0][PSEL_W-1:0] bank_port;
    logic [SCNT_W-1:0]         lose_n;

    smem_bank_grant #(
        .NP(NP), .NB(NB), .BSEL_W(BSEL_W), .PSEL_W(PSEL_W), .SCNT_W(SCNT_W)
    ) grant_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .bank      (bank_v),
        .grant     (grant),
        .bank_en   (bank_en),
        .bank_port (bank_port),
        .lose_n    (lose_n)
    );

    assign req_ready = grant;

    // per-bank storage, driven by the port that won the bank
    logic [NB-1:0][DATA_W-1:0] bank_rdata;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            smem_bank_ram #(
                .ROWS(ROWS), .ROW_W(ROW_W), .DATA_W(DATA_W)
            ) ram_i (
                .clk   (clk),
                .en    (bank_en[b]),
                .we    (req_write[bank_port[b]]),
                .row   (row_v[bank_port[b]]),
                .wdata (wdata_v[bank_port[b]]),
                .rdata (bank_rdata[b])
            );
        end
    endgenerate

    logic [SCNT_W-1:0] n_rd, n_wr;

    always_comb begin
        st_d = st_q;
        n_rd = '0;
        n_wr = '0;
        for (int p = 0; p < NP; p++) begin
            st_d.s1_valid[p] = grant[p] && (!req_write[p] || WR_RSP_EN);
            st_d.s1_read[p]  = !req_write[p];
            st_d.s1_tag[p]   = tag_v[p];
            st_d.s1_rid[p]   = rid_v[p];
            st_d.s1_bank[p]  = bank_v[p];
            if (grant[p] && !req_write[p]) n_rd = n_rd + SCNT_W'(1);
            if (grant[p] &&  req_write[p]) n_wr = n_wr + SCNT_W'(1);
        end
        st_d.rd_cnt = st_q.rd_cnt + CNT_W'(n_rd);
        st_d.wr_cnt = st_q.wr_cnt + CNT_W'(n_wr);
        st_d.st_cnt = st_q.st_cnt + CNT_W'(lose_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_reads  = st_q.rd_cnt;
    assign cnt_writes = st_q.wr_cnt;
    assign cnt_stalls = st_q.st_cnt;

    // response assembly and optional extra delay
    logic [NP-1:0][TAG_W-1:0]  rsp_tag_v;
    logic [NP-1:0][RID_W-1:0]  rsp_rid_v;
    logic [NP-1:0][DATA_W-1:0] rsp_data_v;

    generate
        for (genvar p = 0; p < NP; p++) begin : g_rsp
            logic [DATA_W-1:0] s1_data;
            logic [PAY_W-1:0]  pay_out;

            assign s1_data = st_q.s1_read[p] ? bank_rdata[st_q.s1_bank[p]] : '0;

            smem_rsp_delay #(
                .STAGES(RSP_LAT - 1), .W(PAY_W)
            ) dly_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .in_valid  (st_q.s1_valid[p]),
                .in_pay    ({st_q.s1_tag[p], st_q.s1_rid[p], s1_data}),
                .out_valid (rsp_valid[p]),
                .out_pay   (pay_out)
            );

            assign {rsp_tag_v[p], rsp_rid_v[p], rsp_data_v[p]} = pay_out;

            AST_READY_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                req_ready[p] |-> req_valid[p]); // R4

            if (RSP_LAT == 1) begin : g_lat1
                AST_READ_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
                    (req_valid[p] && req_ready[p] && !req_write[p]) |=> rsp_valid[p]); // R5

                AST_RSP_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
                    rsp_valid[p] |-> $past(req_valid[p] && req_ready[p])); // R5

                if (!WR_RSP_EN) begin : g_nowr
                    AST_WR_RSP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                        (req_valid[p] && req_ready[p] && req_write[p]) |=> !rsp_valid[p]); // R6
                end
            end
        end
    endgenerate

    assign rsp_tag  = rsp_tag_v;
    assign rsp_rid  = rsp_rid_v;
    assign rsp_data = rsp_data_v;

    // one winner per bank
    logic [NB-1:0][NP-1:0] bank_users;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < NP; p++) begin
                bank_users[b][p] = req_ready[p] && (bank_v[p] == BSEL_W'(b));
            end
        end
    end

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bchk
            AST_ONE_GRANT_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(bank_users[b])); // R3
        end
    endgenerate

    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_stalls - $past(cnt_stalls)) <= CNT_W'(NP)); // R8

    AST_RD_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_reads - $past(cnt_reads)) <= CNT_W'(NP)); // R7

endmodule

// File: tb/smem_bank_arb_tb_top.sv
module smem_bank_arb_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [3:0]       v, wr, rdy, rv, nw_rdy, nw_rv;
    logic [3:0][7:0]  addr, tag, rtag, nw_tag;
    logic [3:0][31:0] wd, rdat, nw_dat;
    logic [3:0][3:0]  rid, rrid, nw_rid;
    logic [63:0]      c_rd, c_wr, c_st, n_rd, n_wr, n_st;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    smem_bank_arb dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_ready(rdy), .req_write(wr),
        .req_addr(addr), .req_wdata(wd), .req_tag(tag), .req_rid(rid),
        .rsp_valid(rv), .rsp_tag(rtag), .rsp_rid(rrid), .rsp_data(rdat),
        .cnt_reads(c_rd), .cnt_writes(c_wr), .cnt_stalls(c_st)
    );

    smem_bank_arb #(.WR_RSP_EN(1'b0)) dut_nw_i (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_ready(nw_rdy), .req_write(wr),
        .req_addr(addr), .req_wdata(wd), .req_tag(tag), .req_rid(rid),
        .rsp_valid(nw_rv), .rsp_tag(nw_tag), .rsp_rid(nw_rid), .rsp_data(nw_dat),
        .cnt_reads(n_rd), .cnt_writes(n_wr), .cnt_stalls(n_st)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1 defaults: bank = addr[3:2], row = {addr[7:4], addr[1:0]}
    function automatic logic [7:0] mk_addr(input int row_hi, input int bnk, input int row_lo);
        return {4'(row_hi), 2'(bnk), 2'(row_lo)};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R9 rsp_valid in reset", 64'(rv), 0);
        chk("R9 reads in reset", c_rd, 0);
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R9 rsp_valid after reset", 64'(rv), 0);
        chk("R9 counters after reset", c_rd | c_wr | c_st, 0);
        chk("R4 ready idle", 64'(rdy), 0);
    endtask

    // all ports on distinct banks, write then read back
    task automatic t_spread();
        for (int p = 0; p < 4; p++) begin
            addr[p] = mk_addr(p + 1, p, 1);
            wd[p]   = 32'hC0DE_0000 + p;
            tag[p]  = 8'(8'h20 + p);
            rid[p]  = 4'(p);
        end
        wr = 4'hF; v = 4'hF;
        #1 chk("R10 all distinct banks granted", 64'(rdy), 64'hF);
        @(posedge clk); @(negedge clk);
        v = '0;
        chk("R6 write rsp enabled", 64'(rv), 64'hF);
        chk("R6 write rsp disabled", 64'(nw_rv), 0);
        for (int p = 0; p < 4; p++) begin
            chk("R5 write rsp tag", 64'(rtag[p]), 64'(8'h20 + p));
            chk("R6 write rsp data zero", 64'(rdat[p]), 0);
        end
        chk("R7 writes count", c_wr, 4);
        for (int p = 0; p < 4; p++) tag[p] = 8'(8'h40 + p);
        wr = 4'h0; v = 4'hF;
        #1 chk("R10 reads distinct banks", 64'(rdy), 64'hF);
        @(posedge clk); @(negedge clk);
        v = '0;
        chk("R5 read rsp valid", 64'(rv), 64'hF);
        chk("R5 read rsp valid nw", 64'(nw_rv), 64'hF);
        for (int p = 0; p < 4; p++) begin
            chk("R5 read data", 64'(rdat[p]), 64'(32'hC0DE_0000 + p));
            chk("R5 read tag", 64'(rtag[p]), 64'(8'h40 + p));
            chk("R5 read rid", 64'(rrid[p]), 64'(p));
        end
        chk("R7 reads count", c_rd, 4);
        @(negedge clk);
        chk("R5 single pulse", 64'(rv), 0);
    endtask

    // all ports on bank 2, rows differ outside the bank field
    task automatic t_conflict(input bit is_wr);
        logic [3:0] pend;
        logic [3:0] exp_r;
        logic [63:0] st0;
        st0 = c_st;
        for (int p = 0; p < 4; p++) begin
            addr[p] = mk_addr(p + 8, 2, p);
            wd[p]   = 32'h5EED_0000 + p;
            tag[p]  = 8'(is_wr ? 8'h60 + p : 8'h70 + p);
            rid[p]  = 4'(p + 4);
        end
        wr = {4{is_wr}};
        pend = 4'hF;
        for (int c = 0; c < 4; c++) begin
            v = pend;
            exp_r = pend & (~pend + 4'd1);
            #1 chk("R2 lowest pending port wins", 64'(rdy), 64'(exp_r));
            chk("R4 same grant nw", 64'(nw_rdy), 64'(exp_r));
            @(posedge clk); @(negedge clk);
            pend = pend & ~exp_r;
            chk("R4 one rsp per cycle", 64'(rv), 64'(exp_r));
            chk("R5 rsp tag", 64'(rtag[c]), 64'(is_wr ? 8'h60 + c : 8'h70 + c));
            chk("R5 rsp rid", 64'(rrid[c]), 64'(c + 4));
            if (is_wr) chk("R6 nw silent on write", 64'(nw_rv), 0);
            else chk("R5 conflict read data", 64'(rdat[c]), 64'(32'h5EED_0000 + c));
        end
        v = '0;
        chk("R8 stall increments 3+2+1", c_st - st0, 6);
        chk("R8 nw stalls match", n_st, c_st);
    endtask

    initial begin
        v = '0; wr = '0; addr = '0; wd = '0; tag = '0; rid = '0;
        t_reset();
        t_spread();
        t_conflict(1'b1);
        chk("R7 writes total", c_wr, 8);
        t_conflict(1'b0);
        chk("R7 reads total", c_rd, 8);
        chk("R8 stalls total", c_st, 12);
        chk("R1 row bits keep bank-2 words apart", 64'(rdat[3]), 64'h5EED_0003);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule